// File: doc/BRIEF.md
# Symmetric Pre-Add Decimating FIR Cell

This block is an eight-tap FIR filter cell for 10-bit signed samples and 10-bit signed coefficients. When the coefficient set is symmetric, it adds each pair of mirrored samples before multiplying, so four multipliers cover all eight taps. In asymmetric mode the same four multipliers are used over two consecutive cycles, first on the near half of the taps and then on the far half. Each coefficient set is taken from a private store of 32 sets. A write port loads the store. A set index travels with every accepted sample, so the set can change on every clock with no reload.

A programmable decimation factor N (1 to 16) does two things. It spaces the taps N samples apart, using a delay line of 8 x 16 samples. It also keeps one output for every N accepted samples. A cascade input can replace the normal sample input as the source of the delay line. A cascade output presents the sample that is about to leave the span of eight tap positions. Two cells chained through these ports therefore see one continuous 16-position history. Their two partial results are summed outside the cell.

Top module: `symfir_cell`

## Requirements
- R1: While `rst_n` is low on a clock edge, `y_valid` goes to 0, `y_data` goes to 0 and the delay line is cleared. After reset `casc_out` reads 0, and samples that came before reset count as zero.
- R2: In symmetric mode (`asym_mode`=0) the result is y = sum over k=0..3 of c[k]*(x[k*N] + x[(7-k)*N]). Here x[0] is the newest accepted sample and c[k] is tap k of the set captured with that sample.
- R3: In asymmetric mode (`asym_mode`=1) the result is y = sum over k=0..7 of c[k]*x[k*N]. After every accepted sample, the next cycle must not accept a sample.
- R4: `dec_sel` holds N-1. An accepted sample produces a result when the count of accepted samples since the last result (or since reset) is at least `dec_sel`. No other accepted sample produces a result.
- R5: Tap k reads the sample that was accepted k*N acceptances before the newest one, with N taken from `dec_sel` at acceptance.
- R6: The coefficient set is the value of `set_sel` in the cycle the sample is accepted, and it may differ on every sample.
- R7: A write strobed in cycle w stores `cw_data` at `cw_addr`, where `cw_addr[7:3]` is the set and `cw_addr[2:0]` the tap. Coefficient reads in cycle w still return the old value. Reads from cycle w+1 onward return the new value. Coefficients are read in the cycle after acceptance; asymmetric mode also reads them in the cycle after that.
- R8: With `casc_sel`=1 the delay line takes `casc_in` and ignores `in_data`.
- R9: After each acceptance, `casc_out` holds the sample accepted 8*N-1 acceptances before the newest one, where N comes from the current `dec_sel`. It holds that value until the next acceptance.
- R10: A producing sample with `in_valid` high in cycle t gives `y_valid` high for one cycle, in cycle t+3 for symmetric mode or t+4 for asymmetric mode.
- R11: Full-scale operands give the exact result without wrap. For example, eight taps of -512 times samples of -512 give 2097152 in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cw_en | input | 1 | Coefficient write strobe |
| cw_addr | input | 8 | Coefficient address {set, tap} |
| cw_data | input | 10 | Coefficient write value (signed) |
| set_sel | input | 5 | Coefficient set for the sample being accepted |
| dec_sel | input | 4 | Decimation factor minus one |
| asym_mode | input | 1 | 1 selects two-pass asymmetric mode |
| casc_sel | input | 1 | 1 feeds the delay line from casc_in |
| in_valid | input | 1 | Accept a sample this cycle |
| in_data | input | 10 | Sample input (signed) |
| casc_in | input | 10 | Cascade sample input (signed) |
| casc_out | output | 10 | Sample leaving the eight-tap span |
| y_valid | output | 1 | Result strobe |
| y_data | output | 28 | Filter result (signed) |

## Verification
The bench builds the cell with its default parameters: 10-bit operands, eight taps, 32 sets, a decimation limit of 16 and a 28-bit result. These values reach every set address, the longest tap spacing of 16, which spans the whole 128-sample line, and the largest pre-added products, which test the result width. A reference model in the bench keeps the sample history and a mirror of the coefficient store. It predicts every result and the cycle it appears in, for both modes, for factors 1, 3, 4 and 16, for cascade feeding, for per-sample set changes and for a coefficient write that collides with a read.

// File: rtl/symfir_pkg.sv
// Package: shared types and helpers for the symmetric FIR cell.
// Assumes: tap offsets fit in 32 bits (always true for legal parameters).
package symfir_pkg;

    // Tag carried by a product group to tell the result stage what it holds.
    typedef enum logic [1:0] {
        GRP_SYM     = 2'd0,   // complete symmetric result
        GRP_ASYM_LO = 2'd1,   // near half of an asymmetric result
        GRP_ASYM_HI = 2'd2    // far half of an asymmetric result
    } grp_e;

    // Delay-line position of tap 'tap' when taps are (dec_m1+1) samples apart.
    function automatic int unsigned tap_offset(input int unsigned tap,
                                               input int unsigned dec_m1);
        return tap * (dec_m1 + 1);
    endfunction

    // Delay-line position of the sample about to leave the tap span.
    function automatic int unsigned exit_offset(input int unsigned taps,
                                                input int unsigned dec_m1);
        return taps * (dec_m1 + 1) - 1;
    endfunction

endpackage

// File: rtl/symfir_tapline.sv
// Module: sample delay line with taps whose spacing can be programmed.
// Shifts one sample in per accepted input. Tap k reads position k*N, and
// the cascade output reads position TAPS*N-1.
// Assumes: positions up to TAPS*MAXDEC-1 exist and reset clears them to 0.
module symfir_tapline
    import symfir_pkg::*;
#(
    parameter int DW     = 10,
    parameter int TAPS   = 8,
    parameter int MAXDEC = 16,
    localparam int DEPTH = TAPS * MAXDEC,
    localparam int IDXW  = $clog2(DEPTH),
    localparam int DECW  = $clog2(MAXDEC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift,
    input  logic signed [DW-1:0] din,
    input  logic [DECW-1:0]      tap_dec_m1,
    input  logic [DECW-1:0]      out_dec_m1,
    output logic signed [DW-1:0] taps [TAPS],
    output logic signed [DW-1:0] casc_out
);

    logic signed [DW-1:0] line [DEPTH];
    logic [IDXW-1:0]      exit_idx;

    // Shift the history by one position on every accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) line[i] <= '0;
        end else if (shift) begin
            line[0] <= din;
            for (int i = 1; i < DEPTH; i++) line[i] <= line[i-1];
        end
    end

    // One read mux per tap at the programmed spacing.
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        logic [IDXW-1:0] idx;
        always_comb begin
            idx     = IDXW'(tap_offset(k, int'(tap_dec_m1)));
            taps[k] = line[idx];
        end
    end

    // Cascade read position follows the current decimation setting.
    always_comb begin
        exit_idx = IDXW'(exit_offset(TAPS, int'(out_dec_m1)));
        casc_out = line[exit_idx];
    end

    // R8: the sample shifted in is what tap 0 presents next cycle.
    p_newest_tap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (taps[0] == $past(din)));

    // R9: without a shift and with a steady setting, the cascade output holds.
    p_casc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(shift) && $stable(out_dec_m1)) |-> $stable(casc_out));

endmodule

// File: rtl/symfir_coefbank.sv
// Module: coefficient store with NSETS sets of TAPS signed words.
// One write port; all TAPS words of the selected set are read at once.
// Assumes: contents are not reset; a write lands at the strobe's clock edge,
// so a read in the strobe cycle returns the old word.
module symfir_coefbank #(
    parameter int CW    = 10,
    parameter int TAPS  = 8,
    parameter int NSETS = 32,
    localparam int SETW = $clog2(NSETS),
    localparam int TAPW = $clog2(TAPS),
    localparam int AW   = SETW + TAPW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic signed [CW-1:0] wr_data,
    input  logic [SETW-1:0]      rd_set,
    output logic signed [CW-1:0] coefs [TAPS]
);

    logic signed [CW-1:0] mem [NSETS*TAPS];

    // Store one coefficient per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Read every tap of the selected set.
    for (genvar k = 0; k < TAPS; k++) begin : g_rd
        always_comb coefs[k] = mem[{rd_set, TAPW'(k)}];

        // R7: a word written last cycle is what the read port shows now.
        p_write_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(wr_en) && ($past(wr_addr) == {rd_set, TAPW'(k)}))
                |-> (coefs[k] == $past(wr_data)));
    end

endmodule

// File: rtl/symfir_mac.sv
// Module: pre-adder, HALF multipliers and result stage.
// Symmetric mode: one pass over mirrored sample pairs. Asymmetric mode:
// near-half taps in the start cycle, far-half taps in the next cycle.
// Assumes: taps/coefs hold still for both asymmetric passes, and
// ACCW exceeds the product-sum width.
module symfir_mac
    import symfir_pkg::*;
#(
    parameter int DW   = 10,
    parameter int CW   = 10,
    parameter int TAPS = 8,
    parameter int ACCW = 28,
    localparam int HALF = TAPS / 2,
    localparam int PAW  = DW + 1,
    localparam int PW   = PAW + CW,
    localparam int SUMW = PW + $clog2(HALF) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   asym,
    input  logic signed [DW-1:0]   taps  [TAPS],
    input  logic signed [CW-1:0]   coefs [TAPS],
    output logic                   y_valid,
    output logic signed [ACCW-1:0] y_data
);

    logic                  far_pass;
    logic signed [PAW-1:0] opnd [HALF];
    logic signed [CW-1:0]  cf   [HALF];
    logic signed [PW-1:0]  prod [HALF];
    logic                  prod_v;
    grp_e                  prod_tag;
    logic signed [SUMW-1:0] psum;
    logic signed [SUMW-1:0] near_acc;

    // Schedule the far-half pass right after an asymmetric start.
    always_ff @(posedge clk) begin
        if (!rst_n) far_pass <= 1'b0;
        else        far_pass <= start && asym;
    end

    // Pick pre-added pairs or single taps for each multiplier.
    always_comb begin
        for (int m = 0; m < HALF; m++) begin
            if (far_pass) begin
                opnd[m] = PAW'(taps[m+HALF]);
                cf[m]   = coefs[m+HALF];
            end else if (asym) begin
                opnd[m] = PAW'(taps[m]);
                cf[m]   = coefs[m];
            end else begin
                opnd[m] = PAW'(taps[m]) + PAW'(taps[TAPS-1-m]);
                cf[m]   = coefs[m];
            end
        end
    end

    // Register the products with a tag that says which group they form.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_v   <= 1'b0;
            prod_tag <= GRP_SYM;
            for (int m = 0; m < HALF; m++) prod[m] <= '0;
        end else begin
            prod_v <= start || far_pass;
            if (far_pass)   prod_tag <= GRP_ASYM_HI;
            else if (asym)  prod_tag <= GRP_ASYM_LO;
            else            prod_tag <= GRP_SYM;
            for (int m = 0; m < HALF; m++) prod[m] <= opnd[m] * cf[m];
        end
    end

    // Adder tree over the registered products.
    always_comb begin
        psum = '0;
        for (int m = 0; m < HALF; m++) psum = psum + SUMW'(prod[m]);
    end

    // Hold the near half, then emit a finished result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            near_acc <= '0;
            y_valid  <= 1'b0;
            y_data   <= '0;
        end else begin
            if (prod_v && prod_tag == GRP_ASYM_LO) near_acc <= psum;
            y_valid <= prod_v && (prod_tag != GRP_ASYM_LO);
            if (prod_v && prod_tag == GRP_SYM)
                y_data <= ACCW'(psum);
            else if (prod_v && prod_tag == GRP_ASYM_HI)
                y_data <= ACCW'(psum) + ACCW'(near_acc);
        end
    end

    // R3: a far-half group always follows a near-half group.
    p_two_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_v && prod_tag == GRP_ASYM_HI)
            |-> $past(prod_v && prod_tag == GRP_ASYM_LO));

    // R10: symmetric start gives a result two cycles later.
    p_sym_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !asym) |-> ##2 y_valid);

    // R10: asymmetric start gives a result three cycles later.
    p_asym_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && asym) |-> ##3 y_valid);

endmodule

// File: rtl/symfir_cell.sv
// Module: top of the symmetric pre-add decimating FIR cell.
// Counts accepted samples against the decimation setting, captures the
// set, spacing and mode that travel with each sample, and joins the delay
// line, coefficient store and multiplier stage.
// Assumes: in asymmetric mode no sample is accepted in the cycle after one.
module symfir_cell #(
    parameter int DW     = 10,
    parameter int CW     = 10,
    parameter int TAPS   = 8,
    parameter int NSETS  = 32,
    parameter int MAXDEC = 16,
    parameter int ACCW   = 28,
    localparam int SETW  = $clog2(NSETS),
    localparam int TAPW  = $clog2(TAPS),
    localparam int AW    = SETW + TAPW,
    localparam int DECW  = $clog2(MAXDEC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cw_en,
    input  logic [AW-1:0]          cw_addr,
    input  logic signed [CW-1:0]   cw_data,
    input  logic [SETW-1:0]        set_sel,
    input  logic [DECW-1:0]        dec_sel,
    input  logic                   asym_mode,
    input  logic                   casc_sel,
    input  logic                   in_valid,
    input  logic signed [DW-1:0]   in_data,
    input  logic signed [DW-1:0]   casc_in,
    output logic signed [DW-1:0]   casc_out,
    output logic                   y_valid,
    output logic signed [ACCW-1:0] y_data
);

    logic [DECW-1:0]      phase;
    logic                 fire;
    logic                 s1_fire;
    logic [SETW-1:0]      set_q;
    logic [DECW-1:0]      dec_q;
    logic                 asym_q;
    logic signed [DW-1:0] line_in;
    logic signed [DW-1:0] taps  [TAPS];
    logic signed [CW-1:0] coefs [TAPS];

    // A sample produces a result once the phase reaches the setting.
    always_comb fire = in_valid && (phase >= dec_sel);

    // Delay line source: cascade input or the normal sample input.
    always_comb line_in = casc_sel ? casc_in : in_data;

    // Decimation phase counter over accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n)         phase <= '0;
        else if (fire)      phase <= '0;
        else if (in_valid)  phase <= phase + 1'b1;
    end

    // Capture the per-sample controls used by the compute stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_fire <= 1'b0;
            set_q   <= '0;
            dec_q   <= '0;
            asym_q  <= 1'b0;
        end else begin
            s1_fire <= fire;
            if (in_valid) begin
                set_q  <= set_sel;
                dec_q  <= dec_sel;
                asym_q <= asym_mode;
            end
        end
    end

    symfir_tapline #(
        .DW(DW), .TAPS(TAPS), .MAXDEC(MAXDEC)
    ) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift      (in_valid),
        .din        (line_in),
        .tap_dec_m1 (dec_q),
        .out_dec_m1 (dec_sel),
        .taps       (taps),
        .casc_out   (casc_out)
    );

    symfir_coefbank #(
        .CW(CW), .TAPS(TAPS), .NSETS(NSETS)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cw_en),
        .wr_addr (cw_addr),
        .wr_data (cw_data),
        .rd_set  (set_q),
        .coefs   (coefs)
    );

    symfir_mac #(
        .DW(DW), .CW(CW), .TAPS(TAPS), .ACCW(ACCW)
    ) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (s1_fire),
        .asym    (asym_q),
        .taps    (taps),
        .coefs   (coefs),
        .y_valid (y_valid),
        .y_data  (y_data)
    );

    // R3: the near-half pass cycle must not shift the delay line.
    p_asym_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_fire && asym_q) |-> !in_valid);

    // R4: with N above one, two producing samples are never adjacent
    // unless the setting changed in between.
    p_fire_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && dec_sel != '0) |=> (!fire || dec_sel != $past(dec_sel)));

endmodule

// File: tb/symfir_cell_bench.sv
// Bench: scoreboard for symfir_cell. The driver tasks model the expected
// results and push them into a queue; a monitor pops and compares them.
module symfir_cell_bench;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cw_en = 1'b0;
    logic [7:0]        cw_addr = '0;
    logic signed [9:0] cw_data = '0;
    logic [4:0]        set_sel = '0;
    logic [3:0]        dec_sel = '0;
    logic              asym_mode = 1'b0;
    logic              casc_sel = 1'b0;
    logic              in_valid = 1'b0;
    logic signed [9:0] in_data = '0;
    logic signed [9:0] casc_in = '0;
    logic signed [9:0] casc_out;
    logic              y_valid;
    logic signed [27:0] y_data;

    symfir_cell u_symfir_cell (
        .clk(clk), .rst_n(rst_n), .cw_en(cw_en), .cw_addr(cw_addr),
        .cw_data(cw_data), .set_sel(set_sel), .dec_sel(dec_sel),
        .asym_mode(asym_mode), .casc_sel(casc_sel), .in_valid(in_valid),
        .in_data(in_data), .casc_in(casc_in), .casc_out(casc_out),
        .y_valid(y_valid), .y_data(y_data)
    );

    always #4 clk = ~clk;   // 125 MHz

    int          cyc = 0;
    int          n_checks = 0;
    int          n_err = 0;
    bit          done = 1'b0;
    int unsigned seed = 32'h1234_5678;

    int     cm [32][8];      // coefficient mirror
    int     hist [$];        // line input history, newest at the back
    int     phase = 0;
    int     dec_m1 = 0;
    bit     asym = 1'b0;
    bit     casc = 1'b0;

    longint exp_val [$];
    int     exp_cyc [$];
    string  exp_tag [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req,
                       input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'((seed >> 16) & 32'd1023) - 512;
    endfunction

    function automatic int xv(input int d);
        if (d < hist.size()) return hist[hist.size()-1-d];
        return 0;
    endfunction

    function automatic longint model_y(input int s, input int n, input bit a);
        longint acc = 0;
        if (a) begin
            for (int k = 0; k < 8; k++) acc += longint'(cm[s][k]) * xv(k*n);
        end else begin
            for (int k = 0; k < 4; k++)
                acc += longint'(cm[s][k]) * (xv(k*n) + xv((7-k)*n));
        end
        return acc;
    endfunction

    // Drive one sample; predict its result and check the cascade output.
    task automatic send(input int v, input int s, input int gap, input string tag);
        int n;
        n = dec_m1 + 1;
        set_sel = 5'(s);
        if (casc) begin
            casc_in = 10'(v);
            in_data = 10'(rnd());
        end else begin
            in_data = 10'(v);
        end
        in_valid = 1'b1;
        hist.push_back(v);
        if (phase >= dec_m1) begin
            phase = 0;
            exp_val.push_back(model_y(s, n, asym));
            exp_cyc.push_back(cyc + (asym ? 4 : 3));
            exp_tag.push_back(tag);
        end else begin
            phase++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk($signed(casc_out) == xv(8*n-1), "R9 casc_out",
            longint'($signed(casc_out)), longint'(xv(8*n-1)));
        repeat (gap) @(negedge clk);
    endtask

    task automatic wr(input int s, input int k, input int v);
        cw_en   = 1'b1;
        cw_addr = {5'(s), 3'(k)};
        cw_data = 10'(v);
        cm[s][k] = v;
        @(negedge clk);
        cw_en = 1'b0;
    endtask

    task automatic do_reset();
        repeat (6) @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        hist.delete();
        phase = 0;
        chk(y_valid == 1'b0, "R1 y_valid", longint'(y_valid), 0);
        chk(y_data == '0, "R1 y_data", longint'(y_data), 0);
        chk(casc_out == '0, "R1 casc_out", longint'(casc_out), 0);
    endtask

    task automatic set_mode(input int d, input bit a, input bit c);
        dec_m1 = d;  dec_sel = 4'(d);
        asym = a;    asym_mode = a;
        casc = c;    casc_sel = c;
    endtask

    // Monitor: compare each result with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && y_valid && !done) begin
            if (exp_val.size() == 0) begin
                chk(1'b0, "R4 unexpected result", longint'(y_data), 0);
            end else begin
                longint e;
                int     ec;
                string  t;
                e  = exp_val.pop_front();
                ec = exp_cyc.pop_front();
                t  = exp_tag.pop_front();
                chk(longint'(y_data) == e, t, longint'(y_data), e);
                chk(cyc == ec, "R10 result cycle", longint'(cyc), longint'(ec));
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL R10 watchdog actual=%0d expected=%0d", exp_val.size(), 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 from power-up
        chk(y_valid == 1'b0, "R1 y_valid", longint'(y_valid), 0);
        chk(y_data == '0, "R1 y_data", longint'(y_data), 0);
        chk(casc_out == '0, "R1 casc_out", longint'(casc_out), 0);

        // Load all 32 sets (R7 addressing).
        for (int s = 0; s < 32; s++)
            for (int k = 0; k < 8; k++)
                wr(s, k, ((s*37 + k*91 + 13) % 1023) - 511);

        // R2 symmetric, N=1, back-to-back samples.
        set_mode(0, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) send(rnd(), 0, 0, "R2 symmetric");
        for (int i = 0; i < 6; i++) send(rnd(), 9, 2, "R2 symmetric gapped");

        // R6 set changes on every sample.
        for (int i = 0; i < 16; i++) begin
            int sets [4] = '{0, 5, 31, 12};
            send(rnd(), sets[i % 4], 0, "R6 per-sample set");
        end

        // R1 after activity, then R4/R5 decimation by 3.
        do_reset();
        set_mode(2, 1'b0, 1'b0);
        for (int i = 0; i < 40; i++) send(rnd(), 3, 0, "R5 spacing 3");

        // R4/R5 decimation by 16 over the whole line.
        do_reset();
        set_mode(15, 1'b0, 1'b0);
        for (int i = 0; i < 150; i++) send(rnd(), 17, 0, "R5 spacing 16");

        // R3 asymmetric, N=1 and N=4.
        do_reset();
        set_mode(0, 1'b1, 1'b0);
        for (int i = 0; i < 16; i++) send(rnd(), 21, 1, "R3 asymmetric");
        set_mode(3, 1'b1, 1'b0);
        for (int i = 0; i < 24; i++) send(rnd(), 4, 1, "R3 asymmetric N4");

        // R7 write colliding with the read cycle returns the old word.
        do_reset();
        set_mode(0, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) send(100 + i, 6, 0, "R2 prefill");
        send(200, 6, 0, "R7 old coefficient");
        wr(6, 0, -300);
        send(201, 6, 0, "R7 new coefficient");
        send(202, 6, 2, "R7 new coefficient");

        // R8 cascade feeding ignores in_data.
        do_reset();
        set_mode(1, 1'b0, 1'b1);
        for (int i = 0; i < 30; i++) send(rnd(), 11, 0, "R8 cascade");
        set_mode(0, 1'b1, 1'b1);
        for (int i = 0; i < 10; i++) send(rnd(), 11, 1, "R8 cascade asym");

        // R11 full-scale operands.
        do_reset();
        for (int k = 0; k < 8; k++) wr(30, k, -512);
        for (int k = 0; k < 8; k++) wr(29, k, 511);
        set_mode(0, 1'b0, 1'b0);
        for (int i = 0; i < 10; i++) send(-512, 30, 0, "R11 full scale sym");
        for (int i = 0; i < 10; i++) send(-512, 29, 0, "R11 full scale sym neg");
        set_mode(0, 1'b1, 1'b0);
        for (int i = 0; i < 10; i++) send(-512, 30, 1, "R11 full scale asym");
        for (int i = 0; i < 10; i++) send((i % 2 == 0) ? 511 : -512, 29, 1,
                                          "R11 alternating asym");

        repeat (8) @(negedge clk);
        chk(exp_val.size() == 0, "R4 missing results", longint'(exp_val.size()), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule